// File: doc/BRIEF.md
# Fixed-Point Status Flag Unit

This unit follows a 64-bit fixed-point ALU. From the operands and the ALU result it works out the carry, the carry out of the low word, overflow, overflow of the low word, and the sticky summary overflow. It also builds a four-bit condition field that classifies the result as negative, positive or zero, and appends the summary overflow. It does not add anything itself. The result comes from the ALU, and carry is inferred by asking whether any operand is unsigned-greater than the result. A carry out of the top bit makes the wrapped result smaller than at least one of the operands.

Each instruction presents its operands together with its control flags. The flags select inversion of the first operand, whether a second register operand and an immediate are present, and which flag groups may update. One pulse on `exec_en` commits the enabled updates into the status registers. A flag group that is disabled keeps its previous value. Two flags mark instructions that write the carry bits themselves, so the computed values must not overwrite them.

Top module: `xer_flag_unit`

## Requirements
- R1: When `inv_a` is 1, the first operand is replaced by its bitwise complement before every carry and overflow calculation.
- R2: The operand set always contains the first operand. `op_b` joins it only while `b_vld` is 1, and `imm` joins it only while `imm_vld` is 1. An operand that is absent has no effect on any flag.
- R3: The computed carry `ca` is 1 exactly when some operand in the set is unsigned-greater than the full 64-bit `result`.
- R4: The computed low-word carry `ca32` is 1 exactly when bits 31:0 of some operand are unsigned-greater than bits 31:0 of `result`.
- R5: While `own_ca` is 1, `ca` is not updated. While `own_ca32` is 1, `ca32` is not updated. The two suppressions act independently.
- R6: Overflow compares the first operand with a second one: `op_b` if `b_vld` is 1, otherwise `imm` if `imm_vld` is 1. `ov` is 1 when the two have equal bit 63 and `result` bit 63 differs from it. `ov32` uses the same rule on bit 31. With no second operand, overflow is not updated.
- R7: `so` is sticky. On an overflow update it becomes its old value ORed with the new `ov`. At no other time does it change, except on reset.
- R8: On a record update, `cr0` becomes {negative, positive, zero, so}, with bit 3 = negative and bit 0 = so. The sign is taken from `result` as a signed 64-bit value. The `so` used is the value written in the same strobe.
- R9: Updates take place only on an `exec_en` cycle. Carry updates need `carry_en`, overflow updates need both `ovf_en` and `ovf_vld`, and the condition field needs `rec_en`. Bits that are not updated keep their value.
- R10: A synchronous `rst` clears `ca`, `ca32`, `ov`, `ov32`, `so` and `cr0` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Commit strobe for one instruction |
| op_a | input | 64 | First register operand |
| op_b | input | 64 | Second register operand |
| b_vld | input | 1 | Second register operand present |
| imm | input | 64 | Immediate operand |
| imm_vld | input | 1 | Immediate present |
| result | input | 64 | ALU result |
| inv_a | input | 1 | Complement the first operand |
| carry_en | input | 1 | Allow carry updates |
| ovf_en | input | 1 | Overflow checking requested |
| ovf_vld | input | 1 | Overflow request is valid |
| rec_en | input | 1 | Update the condition field |
| own_ca | input | 1 | Instruction writes the carry itself |
| own_ca32 | input | 1 | Instruction writes the low-word carry itself |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-word carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Low-word overflow |
| so | output | 1 | Summary overflow |
| cr0 | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The carry tests use four kinds of result. A wrap in both words gives both carries. A wrap only out of the low word gives only the low-word carry. A result with no wrap gives neither. The last case changes its answer only because the first operand is inverted. Further tests place a large value in the immediate or in the second operand while its valid bit is low, which shows that only present operands count. For overflow, two patterns tell the 64-bit rule apart from the 32-bit rule, and the immediate stands in as the second operand in one case. Results that are negative, zero and positive, with and without a set summary overflow, are sent through the condition field. The tests also clear each enable and each own-carry flag in turn to confirm that the gated bits hold their value.

// File: rtl/flag_pkg.sv
package flag_pkg;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned LOW_W  = 32;
  parameter int unsigned N_OPS  = 3;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic so;
  } cr_field_t;

  // Equal operand signs and a result sign that differs from them
  function automatic logic sign_flip(input logic x_s, input logic y_s, input logic r_s);
    return (x_s == y_s) && (r_s != x_s);
  endfunction

  // Unsigned greater-than on the low LOW_W bits
  function automatic logic low_ugt(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] r);
    return x[LOW_W-1:0] > r[LOW_W-1:0];
  endfunction
endpackage

// File: rtl/flag_carry_cmp.sv
module flag_carry_cmp
  import flag_pkg::*;
#(
  parameter int unsigned W   = DATA_W,
  parameter int unsigned NOP = N_OPS
) (
  input  logic [NOP-1:0][W-1:0] ops,
  input  logic [NOP-1:0]        ops_vld,
  input  logic [W-1:0]          res,
  output logic                  carry_full,
  output logic                  carry_low
);
  logic [NOP-1:0] gt_full;
  logic [NOP-1:0] gt_low;

  for (genvar i = 0; i < NOP; i++) begin : g_op
    assign gt_full[i] = ops_vld[i] && (ops[i] > res);
    assign gt_low[i]  = ops_vld[i] && low_ugt(ops[i], res);
  end

  assign carry_full = |gt_full;
  assign carry_low  = |gt_low;
endmodule

// File: rtl/flag_ovf_chk.sv
module flag_ovf_chk
  import flag_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned LW = LOW_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] res,
  output logic         ovf_full,
  output logic         ovf_low
);
  localparam int unsigned TOP = W - 1;
  localparam int unsigned LTOP = LW - 1;

  assign ovf_full = sign_flip(x[TOP], y[TOP], res[TOP]);
  assign ovf_low  = sign_flip(x[LTOP], y[LTOP], res[LTOP]);
endmodule

// File: rtl/flag_cr_form.sv
module flag_cr_form
  import flag_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] res,
  input  logic         so_in,
  output cr_field_t    field
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (res == '0);
  assign is_neg  = res[W-1];

  always_comb begin
    field.neg  = is_neg;
    field.pos  = !is_neg && !is_zero;
    field.zero = is_zero;
    field.so   = so_in;
  end
endmodule

// File: rtl/xer_flag_unit.sv
module xer_flag_unit
  import flag_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_en,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         b_vld,
  input  logic [W-1:0] imm,
  input  logic         imm_vld,
  input  logic [W-1:0] result,
  input  logic         inv_a,
  input  logic         carry_en,
  input  logic         ovf_en,
  input  logic         ovf_vld,
  input  logic         rec_en,
  input  logic         own_ca,
  input  logic         own_ca32,
  output logic         ca,
  output logic         ca32,
  output logic         ov,
  output logic         ov32,
  output logic         so,
  output logic [3:0]   cr0
);
  localparam int unsigned NOP = N_OPS;

  // Named internal events, also used by the checker
  logic [W-1:0]          a_eff;
  logic [NOP-1:0][W-1:0] ops;
  logic [NOP-1:0]        ops_vld;
  logic [W-1:0]          second_op;
  logic                  has_second;
  logic                  ca_calc, ca32_calc;
  logic                  ov_calc, ov32_calc;
  logic                  ca_wr, ca32_wr, ov_wr, cr_wr;
  logic                  so_next;
  cr_field_t             cr_next;
  cr_field_t             cr_q;

  assign a_eff      = inv_a ? ~op_a : op_a;
  assign ops        = {imm, op_b, a_eff};
  assign ops_vld    = {imm_vld, b_vld, 1'b1};
  assign has_second = b_vld || imm_vld;
  assign second_op  = b_vld ? op_b : imm;

  flag_carry_cmp #(.W(W), .NOP(NOP)) u_carry (
    .ops        (ops),
    .ops_vld    (ops_vld),
    .res        (result),
    .carry_full (ca_calc),
    .carry_low  (ca32_calc)
  );

  flag_ovf_chk #(.W(W), .LW(LOW_W)) u_ovf (
    .x        (a_eff),
    .y        (second_op),
    .res      (result),
    .ovf_full (ov_calc),
    .ovf_low  (ov32_calc)
  );

  assign ca_wr   = exec_en && carry_en && !own_ca;
  assign ca32_wr = exec_en && carry_en && !own_ca32;
  assign ov_wr   = exec_en && ovf_en && ovf_vld && has_second;
  assign cr_wr   = exec_en && rec_en;
  assign so_next = ov_wr ? (so || ov_calc) : so;

  flag_cr_form #(.W(W)) u_cr (
    .res   (result),
    .so_in (so_next),
    .field (cr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ca   <= 1'b0;
      ca32 <= 1'b0;
      ov   <= 1'b0;
      ov32 <= 1'b0;
      so   <= 1'b0;
      cr_q <= '0;
    end else begin
      if (ca_wr)   ca   <= ca_calc;
      if (ca32_wr) ca32 <= ca32_calc;
      if (ov_wr) begin
        ov   <= ov_calc;
        ov32 <= ov32_calc;
      end
      so <= so_next;
      if (cr_wr) cr_q <= cr_next;
    end
  end

  assign cr0 = cr_q;
endmodule

// File: rtl/flag_unit_checker.sv
module flag_unit_checker (
  input logic       clk,
  input logic       rst,
  input logic       exec_en,
  input logic       carry_en,
  input logic       own_ca,
  input logic       own_ca32,
  input logic       rec_en,
  input logic       ov_wr,
  input logic       ov_calc,
  input logic       ca,
  input logic       ca32,
  input logic       ov,
  input logic       ov32,
  input logic       so,
  input logic [3:0] cr0
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable({ca, ca32, ov, ov32, so, cr0})); // R9
  AST_NO_CARRY_EN: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !carry_en) |=> $stable({ca, ca32})); // R9
  AST_OWN_CA: assert property (@(posedge clk) disable iff (rst)
    (exec_en && own_ca) |=> $stable(ca)); // R5
  AST_OWN_CA32: assert property (@(posedge clk) disable iff (rst)
    (exec_en && own_ca32) |=> $stable(ca32)); // R5
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    so |=> so); // R7
  AST_SO_FROM_OV: assert property (@(posedge clk) disable iff (rst)
    (ov_wr && ov_calc) |=> (so && ov)); // R7
  AST_CR_SO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (exec_en && rec_en) |=> (cr0[0] == so)); // R8
  AST_CR_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    (exec_en && rec_en) |=> $onehot0(cr0[3:1]) && (cr0[3:1] != 3'b000)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> ({ca, ca32, ov, ov32, so, cr0} == 9'd0)); // R10
endmodule

bind xer_flag_unit flag_unit_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .exec_en  (exec_en),
  .carry_en (carry_en),
  .own_ca   (own_ca),
  .own_ca32 (own_ca32),
  .rec_en   (rec_en),
  .ov_wr    (ov_wr),
  .ov_calc  (ov_calc),
  .ca       (ca),
  .ca32     (ca32),
  .ov       (ov),
  .ov32     (ov32),
  .so       (so),
  .cr0      (cr0)
);

// File: tb/tb_xer_flag_unit.sv
module tb_xer_flag_unit;
  logic        clk = 1'b0;
  logic        rst, exec_en;
  logic [63:0] op_a, op_b, imm, result;
  logic        b_vld, imm_vld, inv_a, carry_en, ovf_en, ovf_vld, rec_en, own_ca, own_ca32;
  logic        ca, ca32, ov, ov32, so;
  logic [3:0]  cr0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  xer_flag_unit dut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_a(op_a), .op_b(op_b), .b_vld(b_vld),
    .imm(imm), .imm_vld(imm_vld), .result(result), .inv_a(inv_a), .carry_en(carry_en),
    .ovf_en(ovf_en), .ovf_vld(ovf_vld), .rec_en(rec_en), .own_ca(own_ca),
    .own_ca32(own_ca32), .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr0(cr0)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    exec_en = 0; op_a = 0; op_b = 0; imm = 0; result = 0; b_vld = 0; imm_vld = 0;
    inv_a = 0; carry_en = 0; ovf_en = 0; ovf_vld = 0; rec_en = 0; own_ca = 0; own_ca32 = 0;
  endtask

  // One strobe: inputs set at negedge, register at posedge, sample at next negedge
  task automatic fire(input logic [63:0] a, input logic [63:0] b, input logic bv,
                      input logic [63:0] im, input logic iv, input logic [63:0] r);
    op_a = a; op_b = b; b_vld = bv; imm = im; imm_vld = iv; result = r; exec_en = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle(); rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 reset flags", {3'b0, ca, ca32, ov, ov32, so}, 8'h00);
    chk("R10 reset cr0", {4'b0, cr0}, 8'h00);
  endtask

  task automatic t_carry_patterns();
    do_reset();
    carry_en = 1; fire(ONES, 64'd2, 1, 0, 0, 64'd1);
    chk("R3 wrap both words", {6'b0, ca, ca32}, 8'h03);
    carry_en = 1; fire(64'h0000_0000_FFFF_FFFF, 64'd1, 1, 0, 0, 64'h1_0000_0000);
    chk("R4 low word wrap only", {6'b0, ca, ca32}, 8'h01);
    carry_en = 1; fire(64'd5, 64'd3, 1, 0, 0, 64'd8);
    chk("R3 no wrap", {6'b0, ca, ca32}, 8'h00);
  endtask

  task automatic t_invert();
    do_reset();
    carry_en = 1; inv_a = 1; fire(64'd0, 64'd0, 1, 0, 0, 64'd5);
    chk("R1 complemented operand gives carry", {6'b0, ca, ca32}, 8'h03);
    carry_en = 1; fire(64'd0, 64'd0, 1, 0, 0, 64'd5);
    chk("R1 plain operand no carry", {6'b0, ca, ca32}, 8'h00);
  endtask

  task automatic t_operand_set();
    do_reset();
    carry_en = 1; fire(64'd3, 64'd0, 0, 64'h100, 1, 64'h50);
    chk("R2 immediate counted", {6'b0, ca, ca32}, 8'h03);
    carry_en = 1; fire(64'd3, ONES, 0, 64'h100, 0, 64'h50);
    chk("R2 absent operands ignored", {6'b0, ca, ca32}, 8'h00);
  endtask

  task automatic t_own_carry();
    do_reset();
    carry_en = 1; own_ca = 1; fire(ONES, 64'd2, 1, 0, 0, 64'd1);
    chk("R5 own_ca suppresses ca only", {6'b0, ca, ca32}, 8'h01);
    do_reset();
    carry_en = 1; own_ca32 = 1; fire(ONES, 64'd2, 1, 0, 0, 64'd1);
    chk("R5 own_ca32 suppresses ca32 only", {6'b0, ca, ca32}, 8'h02);
  endtask

  task automatic t_overflow();
    do_reset();
    ovf_en = 1; ovf_vld = 1; fire(MAXP, 64'd1, 1, 0, 0, MINN);
    chk("R6 64-bit overflow", {5'b0, ov, ov32, so}, 8'h05);
    ovf_en = 1; ovf_vld = 1; fire(64'h7FFF_FFFF, 64'd1, 1, 0, 0, 64'h8000_0000);
    chk("R6 R7 32-bit overflow, so sticky", {5'b0, ov, ov32, so}, 8'h03);
    ovf_en = 1; ovf_vld = 0; fire(MAXP, 64'd1, 1, 0, 0, MINN);
    chk("R9 overflow not valid holds", {5'b0, ov, ov32, so}, 8'h03);
    do_reset();
    ovf_en = 1; ovf_vld = 1; fire(MAXP, 64'd0, 0, 0, 0, MINN);
    chk("R6 single operand no update", {5'b0, ov, ov32, so}, 8'h00);
    ovf_en = 1; ovf_vld = 1; fire(MAXP, 64'd0, 0, 64'd1, 1, MINN);
    chk("R6 immediate as second operand", {5'b0, ov, ov32, so}, 8'h05);
  endtask

  task automatic t_cr0();
    do_reset();
    rec_en = 1; fire(0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFB);
    chk("R8 negative", {4'b0, cr0}, 8'h08);
    rec_en = 1; fire(0, 0, 0, 0, 0, 64'd0);
    chk("R8 zero", {4'b0, cr0}, 8'h02);
    rec_en = 1; fire(0, 0, 0, 0, 0, 64'd7);
    chk("R8 positive", {4'b0, cr0}, 8'h04);
    rec_en = 1; ovf_en = 1; ovf_vld = 1; fire(MAXP, 64'd1, 1, 0, 0, MINN);
    chk("R8 same-strobe so", {4'b0, cr0}, 8'h09);
    fire(0, 0, 0, 0, 0, 64'd0);
    chk("R9 rec_en low holds cr0", {4'b0, cr0}, 8'h09);
  endtask

  task automatic t_gating();
    do_reset();
    fire(ONES, 64'd2, 1, 0, 0, 64'd1);
    chk("R9 carry_en low holds", {6'b0, ca, ca32}, 8'h00);
    op_a = ONES; op_b = 64'd2; b_vld = 1; result = 64'd1; carry_en = 1; exec_en = 0;
    @(negedge clk);
    idle();
    chk("R9 no strobe holds", {6'b0, ca, ca32}, 8'h00);
  endtask

  initial begin
    rst = 1; idle();
    t_reset();
    t_carry_patterns();
    t_invert();
    t_operand_set();
    t_own_carry();
    t_overflow();
    t_cr0();
    t_gating();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule